// File: doc/BRIEF.md
# Two-Pass Bilinear Sub-Pixel Interpolator

This block forms a predicted block of high-bit-depth samples at a fractional position. Each row of source samples enters through a handshake. The block first filters the row along the horizontal axis. It then filters along the vertical axis, pairing each horizontally filtered row with the one that came before it. Each axis has a 3-bit offset that selects one of three paths: a plain copy, a rounding average of two neighbours, or a weighted two-tap blend whose weights always sum to 16.

A block starts with a one-cycle `start` pulse, which captures both offsets and the number of output rows. The source then streams in rows that are one sample wider than the output, so the rightmost output column has its right-hand neighbour. When the vertical offset is nonzero, the first row only primes the internal line buffer, so the source supplies one more row than the block returns. Result rows leave one per handshake beat, and `out_last` marks the final beat. Address generation, edge padding and any error measurement belong to the surrounding logic.

Top module: `bilin_subpel_interp`

## Requirements
- R1: For an offset o in {1,2,3,5,6,7}, the pass computes (wa*p + wb*q + 8) >> 4, where wb = 2*o and wa = 16 - wb. Here p is the current sample and q is its neighbour. The arithmetic is done on 16-bit lanes.
- R2: An offset of 0 on an axis copies that axis's input sample unchanged.
- R3: An offset of 4 on an axis gives (p + q + 1) >> 1.
- R4: Input sample j sits at bits [j*SW +: SW] of `in_row`, for j = 0..W. In the horizontal pass, the neighbour q of output column j is input sample j+1.
- R5: The horizontal pass runs first. In the vertical pass, p is the filtered sample of the earlier row and q is the same column of the next row. With a nonzero vertical offset the block accepts rows+1 input rows; otherwise it accepts exactly rows input rows.
- R6: The block keeps each filtered input row after the first and reuses it. Row k serves as the lower tap of output row k-1 and as the upper tap of output row k.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_row` holds its value. Output column j sits at bits [j*SW +: SW].
- R8: `out_last` is high only with the final output row. After that beat, `out_valid` and `in_ready` are low until the next `start`.
- R9: The offsets and the row count are captured at `start`. A `start` pulse while a block is in progress has no effect on that block.
- R10: Full-scale 12-bit samples (4095) give exact results for every offset, with no wrap in the 16-bit lanes.
- R11: After reset, `out_valid`, `out_last` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a block when the block is idle |
| x_ofs | input | 3 | Horizontal sub-pixel offset |
| y_ofs | input | 3 | Vertical sub-pixel offset |
| rows | input | RW | Number of output rows (1 or more) |
| in_valid | input | 1 | Source row available |
| in_ready | output | 1 | Block accepts a source row |
| in_row | input | (W+1)*SW | Source row of W+1 samples |
| out_valid | output | 1 | Result row available |
| out_ready | input | 1 | Consumer accepts the result row |
| out_row | output | W*SW | Result row of W samples |
| out_last | output | 1 | Marks the final result row of the block |

## Verification
The checker's properties assume the sink obeys the handshake and that `start` carries a row count of at least one. A count of zero would leave the block waiting with no row to return. They also assume samples stay within 12 bits, which is what keeps the 16-bit lanes from wrapping. The bench drives only counts between 1 and 8 and only 12-bit data. It raises `start` a second time solely while a block is in progress. It applies back-pressure in a fixed pattern, so the hold behaviour is exercised without breaking the handshake.

// File: rtl/bilin_pkg.sv
package bilin_pkg;

    localparam int OFS_W     = 3;
    localparam int LANE_W    = 16;
    localparam int WGT_W     = 5;
    localparam int TAP_SHIFT = 4;
    localparam logic [OFS_W-1:0]  HALF_OFS = 3'd4;
    localparam logic [WGT_W-1:0]  WGT_SUM  = 5'd16;
    localparam logic [LANE_W-1:0] TAP_RND  = 16'd8;

    typedef enum logic [1:0] {
        PASS_MODE = 2'd0,
        AVG_MODE  = 2'd1,
        TAP_MODE  = 2'd2
    } pass_mode_e;

    typedef struct packed {
        pass_mode_e       mode;
        logic [WGT_W-1:0] wa;
        logic [WGT_W-1:0] wb;
    } pass_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_e;

    // Turn a 3-bit offset into a path choice and a weight pair.
    function automatic pass_cfg_t decode_ofs(input logic [OFS_W-1:0] ofs);
        pass_cfg_t c;
        c.wb = {1'b0, ofs, 1'b0};
        c.wa = WGT_SUM - c.wb;
        if (ofs == '0)
            c.mode = PASS_MODE;
        else if (ofs == HALF_OFS)
            c.mode = AVG_MODE;
        else
            c.mode = TAP_MODE;
        return c;
    endfunction

    // One output lane from a sample p and its neighbour q.
    function automatic logic [LANE_W-1:0] two_tap(input pass_cfg_t c,
                                                  input logic [LANE_W-1:0] p,
                                                  input logic [LANE_W-1:0] q);
        logic [LANE_W-1:0] acc;
        logic [LANE_W:0]   sum;
        logic [LANE_W-1:0] res;
        acc = '0;
        sum = '0;
        case (c.mode)
            PASS_MODE: res = p;
            AVG_MODE: begin
                sum = {1'b0, p} + {1'b0, q} + {{LANE_W{1'b0}}, 1'b1};
                res = sum[LANE_W:1];
            end
            default: begin
                acc = LANE_W'(c.wa) * p + LANE_W'(c.wb) * q + TAP_RND;
                res = acc >> TAP_SHIFT;
            end
        endcase
        return res;
    endfunction

endpackage

// File: rtl/bilin_hpass.sv
module bilin_hpass
    import bilin_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 12
) (
    input  pass_cfg_t             cfg,
    input  logic [(W+1)*SW-1:0]   row_in,
    output logic [W*SW-1:0]       row_out
);
    for (genvar j = 0; j < W; j++) begin : g_lane
        logic [LANE_W-1:0] p, q, r;
        assign p = LANE_W'(row_in[j*SW +: SW]);
        assign q = LANE_W'(row_in[(j+1)*SW +: SW]);
        assign r = two_tap(cfg, p, q);
        assign row_out[j*SW +: SW] = r[SW-1:0];
    end
endmodule

// File: rtl/bilin_vpass.sv
module bilin_vpass
    import bilin_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 12
) (
    input  pass_cfg_t        cfg,
    input  logic [W*SW-1:0]  upper,
    input  logic [W*SW-1:0]  lower,
    output logic [W*SW-1:0]  row_out
);
    for (genvar j = 0; j < W; j++) begin : g_lane
        logic [LANE_W-1:0] p, q, r;
        assign p = LANE_W'(upper[j*SW +: SW]);
        assign q = LANE_W'(lower[j*SW +: SW]);
        // With no vertical offset the current row goes straight through.
        assign r = (cfg.mode == PASS_MODE) ? q : two_tap(cfg, p, q);
        assign row_out[j*SW +: SW] = r[SW-1:0];
    end
endmodule

// File: rtl/bilin_linebuf.sv
module bilin_linebuf #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/bilin_ctrl.sv
module bilin_ctrl
    import bilin_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OFS_W-1:0] x_ofs,
    input  logic [OFS_W-1:0] y_ofs,
    input  logic [RW-1:0]    rows,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             out_load,
    output logic             buf_load,
    output pass_cfg_t        hcfg,
    output pass_cfg_t        vcfg
);
    localparam int CW = RW + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    ctrl_state_e   state;
    logic [CW-1:0] in_left;
    logic [CW-1:0] out_left;
    logic          prime;
    logic          accept;
    logic          y_active;

    assign y_active = (y_ofs != '0);
    assign in_ready = (state == ST_RUN) && (in_left != '0) && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;
    assign buf_load = accept;
    assign out_load = accept && !prime;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            in_left  <= '0;
            out_left <= '0;
            prime    <= 1'b0;
            hcfg     <= decode_ofs('0);
            vcfg     <= decode_ofs('0);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        hcfg     <= decode_ofs(x_ofs);
                        vcfg     <= decode_ofs(y_ofs);
                        in_left  <= CW'(rows) + CW'(y_active);
                        out_left <= CW'(rows);
                        prime    <= y_active;
                        state    <= ST_RUN;
                    end
                end
                default: begin
                    if (accept) begin
                        in_left <= in_left - ONE;
                        if (prime)
                            prime <= 1'b0;
                        else
                            out_left <= out_left - ONE;
                    end
                    if (out_valid && out_ready && out_last)
                        state <= ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else if (out_load) begin
            out_valid <= 1'b1;
            out_last  <= (out_left == ONE);
        end else if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end
endmodule

// File: rtl/bilin_subpel_interp.sv
module bilin_subpel_interp
    import bilin_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 12,
    parameter int RW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2:0]           x_ofs,
    input  logic [2:0]           y_ofs,
    input  logic [RW-1:0]        rows,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [(W+1)*SW-1:0]  in_row,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [W*SW-1:0]      out_row,
    output logic                 out_last
);
    localparam int ROW_BITS = W * SW;

    pass_cfg_t             hcfg, vcfg;
    logic                  out_load, buf_load;
    logic [ROW_BITS-1:0]   hrow, prev_row, vrow;

    bilin_ctrl #(.RW(RW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .x_ofs(x_ofs), .y_ofs(y_ofs), .rows(rows),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
        .out_load(out_load), .buf_load(buf_load),
        .hcfg(hcfg), .vcfg(vcfg)
    );

    bilin_hpass #(.W(W), .SW(SW)) u_hpass (
        .cfg(hcfg), .row_in(in_row), .row_out(hrow)
    );

    bilin_linebuf #(.WIDTH(ROW_BITS)) u_linebuf (
        .clk(clk), .rst(rst), .load(buf_load), .d(hrow), .q(prev_row)
    );

    bilin_vpass #(.W(W), .SW(SW)) u_vpass (
        .cfg(vcfg), .upper(prev_row), .lower(hrow), .row_out(vrow)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_row <= '0;
        else if (out_load)
            out_row <= vrow;
    end
endmodule

// File: rtl/bilin_subpel_chk.sv
module bilin_subpel_chk #(
    parameter int W  = 8,
    parameter int SW = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [W*SW-1:0]   out_row
);
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_row)); // R7
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R8
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready)); // R8
    AST_ROW_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R5
endmodule

bind bilin_subpel_interp bilin_subpel_chk #(.W(W), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_row(out_row)
);

// File: tb/sim_bilin_subpel_interp.sv
`timescale 1ns/1ps
module sim_bilin_subpel_interp;
    localparam int W  = 4;
    localparam int SW = 12;
    localparam int RW = 5;
    localparam int MAXR = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] x_ofs = '0, y_ofs = '0;
    logic [RW-1:0] rows = '0;
    logic in_valid = 1'b0, in_ready;
    logic [(W+1)*SW-1:0] in_row = '0;
    logic out_valid, out_ready = 1'b0, out_last;
    logic [W*SW-1:0] out_row;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int unsigned seed = 32'h1234_5678;
    int pix [MAXR][W+1];
    int hout[MAXR][W];

    always #2.5 clk = ~clk;

    bilin_subpel_interp #(.W(W), .SW(SW), .RW(RW)) u0 (
        .clk(clk), .rst(rst), .start(start), .x_ofs(x_ofs), .y_ofs(y_ofs),
        .rows(rows), .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_last(out_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual hung run, expected completion");
            errors = errors + 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic int model(int o, int p, int q);
        if (o == 0) return p;
        if (o == 4) return (p + q + 1) / 2;
        return ((16 - 2*o) * p + 2*o * q + 8) / 16;
    endfunction

    function automatic int next_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFFF);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // pattern 0: pseudo-random, 1: all 4095, 2: alternating 4095/0
    task automatic run_block(input int x, input int y, input int nrows,
                             input bit stall, input bit poke, input int pattern);
        int nin, ii, oo, cyc;
        bit have_hold;
        logic [W*SW-1:0] held, exp_row;
        string tag;
        nin = nrows + ((y != 0) ? 1 : 0);
        for (int r = 0; r < nin; r++)
            for (int c = 0; c <= W; c++)
                pix[r][c] = (pattern == 0) ? next_val() :
                            (pattern == 1) ? 4095 : (((r + c) % 2 == 0) ? 4095 : 0);
        for (int r = 0; r < nin; r++)
            for (int c = 0; c < W; c++)
                hout[r][c] = model(x, pix[r][c], pix[r][c+1]);
        tag = "R4 R5 R6";
        if (x == 0 || y == 0) tag = {tag, " R2"};
        if (x == 4 || y == 4) tag = {tag, " R3"};
        if ((x != 0 && x != 4) || (y != 0 && y != 4)) tag = {tag, " R1"};
        if (poke) tag = {tag, " R9"};
        if (pattern != 0) tag = {tag, " R10"};

        @(negedge clk);
        start = 1'b1; x_ofs = 3'(x); y_ofs = 3'(y); rows = RW'(nrows);
        @(negedge clk);
        start = 1'b0;
        ii = 0; oo = 0; cyc = 0; have_hold = 0; held = '0;
        while (oo < nrows && cyc < 2000) begin
            out_ready = stall ? (cyc % 3 == 2) : 1'b1;
            start = poke && (cyc == 0);
            x_ofs = 3'(7 - x); y_ofs = 3'(7 - y); rows = RW'(1);
            in_valid = (ii < nin);
            if (ii < nin)
                for (int c = 0; c <= W; c++) in_row[c*SW +: SW] = SW'(pix[ii][c]);
            #1;
            if (have_hold)
                check(out_valid && out_row == held, "R7 hold", 64'(out_row), 64'(held));
            have_hold = out_valid && !out_ready;
            held = out_row;
            if (out_valid && out_ready) begin
                for (int c = 0; c < W; c++)
                    exp_row[c*SW +: SW] = SW'((y == 0) ? hout[oo][c] : model(y, hout[oo][c], hout[oo+1][c]));
                check(out_row == exp_row, tag, 64'(out_row), 64'(exp_row));
                check(out_last == (oo == nrows - 1), "R8 last flag", 64'(out_last), 64'(oo == nrows - 1));
                oo++;
            end
            if (in_valid && in_ready) ii++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; start = 1'b0; out_ready = 1'b0;
        #1;
        check(cyc < 2000, "R5 block completion", 64'(cyc), 64'd0);
        check(ii == nin, "R5 input row count", 64'(ii), 64'(nin));
        check(!out_valid && !in_ready, "R8 idle after last", {62'd0, out_valid, in_ready}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && !out_last && !in_ready, "R11 reset state",
              {61'd0, out_valid, out_last, in_ready}, 64'd0);
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
                run_block(x, y, (x + y) % 4 + 1, (x + y) % 2 == 1, x == y, 0);
        run_block(7, 7, 8, 1'b0, 1'b0, 1);
        run_block(1, 3, 8, 1'b1, 1'b0, 2);
        run_block(6, 4, 8, 1'b0, 1'b0, 2);
        run_block(4, 6, 3, 1'b1, 1'b0, 1);
        run_block(3, 0, 8, 1'b0, 1'b1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule